// File: doc/BRIEF.md
# Indexed Event Counter Bank with Threshold Interrupts

The block holds a bank of hardware event counters. Each counter watches one condition chosen from an input vector of event strobes and adds one on every clock edge where that condition is high. Software reaches the bank through a narrow register port: a write strobe, a 12-bit address and 32-bit data, with reads returned combinationally. The per-counter registers (condition select, count halves, threshold halves) are not mapped once per counter. Instead they sit behind a single index register, and every access goes to the counter that index currently names.

Each counter has a 64-bit threshold. When a counter's value equals its threshold and that counter's interrupt is enabled, a per-counter pending flag is raised. A single interrupt line is high whenever some counter has both its pending flag and its enable bit set. Clearing a pending flag also drops the enable bit of the same counter, so the handler must re-arm the counter explicitly.

A global control register can zero every count at once and can copy every count into a snapshot. The count registers return that snapshot when read, which gives software a consistent view of the whole bank. A read-only build word describes the configuration. The parameter `SIZE_CODE` sets the count width to 32 + 16*SIZE_CODE bits and is limited to 0..2.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset all counts, snapshots, thresholds, condition selects, the index, the enable mask and the pending flags are zero, and `irq` is low. Address 0x25A reads the build word {NUM_EVT[31:24], NUM_CTR[23:16], 5'b0, 1'b1 at bit 10, SIZE_CODE[9:8], VERSION[7:0]}. Unmapped addresses and the control register read as zero.
- R2: A condition select value k in 1..NUM_EVT makes the counter add one on each clock edge where `events[k-1]` is high. A value of 0, or any value above NUM_EVT, stops counting.
- R3: The index register lives at 0x256 (8 bits, readable). The condition select at 0x254, count low at 0x250, count high at 0x251, threshold low at 0x25C and threshold high at 0x25D act only on the indexed counter. Condition select and both threshold halves read back for the indexed counter.
- R4: Writing the control register at 0x255 with bit 16 set zeroes every count at that edge. This has priority over count writes and increments in the same cycle.
- R5: Writing the control register with bit 17 set copies every count into its snapshot at that edge. Reads of 0x250 and 0x251 return snapshot bits [31:0] and the upper bits zero-extended. A snapshot does not change until the next snapshot command. With bits 16 and 17 set together, the snapshot takes the counts from before the clear.
- R6: The count is 32 + 16*SIZE_CODE bits wide. A write to 0x250 replaces bits [31:0]. A write to 0x251 replaces the upper bits, and data bits beyond the count width are dropped.
- R7: A counter's pending flag is set on the edge where its count equals its zero-extended 64-bit threshold while its enable bit is set. With the enable bit clear, a match leaves the flag clear.
- R8: The enable mask at 0x25E holds one bit per counter (bit i for counter i) and is readable. `irq` is high exactly when some counter has both its pending flag and its enable bit set, and it follows those registers in the same cycle.
- R9: The pending flags at 0x25F are readable and write-1-to-clear. Each 1 written clears that counter's pending flag and its enable bit at the same edge. Writing all ones clears the whole bank.
- R10: While the index is NUM_CTR or above, writes to the per-counter registers change nothing and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| events | input | NUM_EVT | Event condition strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt, OR over counters of pending AND enabled |

## Verification
Register writes take effect at the first rising edge where `reg_wr` is high, and read data is combinational. The bench therefore drives each write for one edge and then reads the register back half a cycle later. An event driven before edge n changes the count at edge n. The threshold comparison sees that new count one edge later. As a result, with a threshold of five and the event held high, `irq` is still low after the fifth edge and high after the sixth, and the bench samples both of those cycles on falling edges. Counts are only observed through the snapshot path, so every count check first sets all events to zero, then issues a snapshot and reads the result one cycle after that snapshot.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

  localparam logic [11:0] A_CNT_LO = 12'h250;
  localparam logic [11:0] A_CNT_HI = 12'h251;
  localparam logic [11:0] A_CFG    = 12'h254;
  localparam logic [11:0] A_CTL    = 12'h255;
  localparam logic [11:0] A_IDX    = 12'h256;
  localparam logic [11:0] A_BUILD  = 12'h25A;
  localparam logic [11:0] A_THR_LO = 12'h25C;
  localparam logic [11:0] A_THR_HI = 12'h25D;
  localparam logic [11:0] A_EN     = 12'h25E;
  localparam logic [11:0] A_ACT    = 12'h25F;

  localparam int CTL_CLR_BIT  = 16;
  localparam int CTL_SNAP_BIT = 17;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic cfg;
    logic ctl;
    logic idx;
    logic thr_lo;
    logic thr_hi;
    logic en;
    logic act;
  } wr_strb_t;

  function automatic int count_width(input int size_code);
    return 32 + 16 * size_code;
  endfunction

  function automatic logic [31:0] build_word(input logic [7:0] ver,
                                             input logic [1:0] size_code,
                                             input logic [7:0] n_ctr,
                                             input logic [7:0] n_evt);
    return {n_evt, n_ctr, 5'b00000, 1'b1, size_code, ver};
  endfunction

  function automatic wr_strb_t decode_wr(input logic wr, input logic [11:0] addr);
    wr_strb_t s;
    s        = '0;
    s.cnt_lo = wr && (addr == A_CNT_LO);
    s.cnt_hi = wr && (addr == A_CNT_HI);
    s.cfg    = wr && (addr == A_CFG);
    s.ctl    = wr && (addr == A_CTL);
    s.idx    = wr && (addr == A_IDX);
    s.thr_lo = wr && (addr == A_THR_LO);
    s.thr_hi = wr && (addr == A_THR_HI);
    s.en     = wr && (addr == A_EN);
    s.act    = wr && (addr == A_ACT);
    return s;
  endfunction

endpackage

// File: rtl/evt_ctr_regs.sv
module evt_ctr_regs
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [11:0]         reg_addr,
  input  logic [7:0]          idx_wdata,
  input  logic [31:0]         sel_cfg,
  input  logic [63:0]         sel_snap,
  input  logic [63:0]         sel_thr,
  input  logic [NUM_CTR-1:0]  en_q,
  input  logic [NUM_CTR-1:0]  act_q,
  input  logic [31:0]         build,
  output wr_strb_t            strb,
  output logic [7:0]          idx_q,
  output logic                idx_ok,
  output logic [31:0]         rdata
);

  assign strb   = decode_wr(reg_wr, reg_addr);
  assign idx_ok = int'(idx_q) < NUM_CTR;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (strb.idx) idx_q <= idx_wdata;
  end

  always_comb begin
    rdata = '0;
    unique case (reg_addr)
      A_CNT_LO: rdata = idx_ok ? sel_snap[31:0]  : '0;
      A_CNT_HI: rdata = idx_ok ? sel_snap[63:32] : '0;
      A_CFG:    rdata = idx_ok ? sel_cfg         : '0;
      A_THR_LO: rdata = idx_ok ? sel_thr[31:0]   : '0;
      A_THR_HI: rdata = idx_ok ? sel_thr[63:32]  : '0;
      A_IDX:    rdata = {24'b0, idx_q};
      A_EN:     rdata = 32'(en_q);
      A_ACT:    rdata = 32'(act_q);
      A_BUILD:  rdata = build;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
  import evt_ctr_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int CW      = 48,
  parameter int CFG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events,
  input  logic               sel,
  input  wr_strb_t           strb,
  input  logic [31:0]        wdata,
  input  logic               clr_all,
  input  logic               snap_all,
  output logic [CFG_W-1:0]   cfg_q,
  output logic [CW-1:0]      cnt_q,
  output logic [CW-1:0]      snap_q,
  output logic [63:0]        thr_q,
  output logic               match
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= NUM_EVT; k++) begin
      if (int'(cfg_q) == k) hit = events[k-1];
    end
  end

  assign match = (64'(cnt_q) == thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_all) begin
      cnt_q <= '0;
    end else if (sel && strb.cnt_lo) begin
      cnt_q <= (cnt_q & ~CW'(32'hFFFF_FFFF)) | CW'(wdata);
    end else if (sel && strb.cnt_hi) begin
      cnt_q <= CW'({wdata, cnt_q[31:0]});
    end else if (hit) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      thr_q  <= '0;
      snap_q <= '0;
    end else begin
      if (sel && strb.cfg)    cfg_q        <= wdata[CFG_W-1:0];
      if (sel && strb.thr_lo) thr_q[31:0]  <= wdata;
      if (sel && strb.thr_hi) thr_q[63:32] <= wdata;
      if (snap_all)           snap_q       <= cnt_q;
    end
  end

endmodule

// File: rtl/evt_ctr_irq.sv
module evt_ctr_irq #(
  parameter int NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] match,
  input  logic               en_wr,
  input  logic               act_w1c,
  input  logic [NUM_CTR-1:0] wbits,
  output logic [NUM_CTR-1:0] en_q,
  output logic [NUM_CTR-1:0] act_q,
  output logic [NUM_CTR-1:0] act_set,
  output logic               irq
);

  logic [NUM_CTR-1:0] clr_bits;

  assign clr_bits = act_w1c ? wbits : '0;
  assign act_set  = match & en_q & ~clr_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= '0;
    end else begin
      if (en_wr) en_q <= wbits;
      else       en_q <= en_q & ~clr_bits;
      act_q <= (act_q & ~clr_bits) | act_set;
    end
  end

  assign irq = |(act_q & en_q);

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int          NUM_CTR   = 4,
  parameter int          NUM_EVT   = 8,
  parameter int          SIZE_CODE = 1,
  parameter logic [7:0]  VERSION   = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);

  localparam int CW    = count_width(SIZE_CODE);
  localparam int CFG_W = $clog2(NUM_EVT + 1);

  wr_strb_t            strb;
  logic [7:0]          idx_q;
  logic                idx_ok;
  logic                clr_all;
  logic                snap_all;
  logic [NUM_CTR-1:0]  match;
  logic [NUM_CTR-1:0]  en_q;
  logic [NUM_CTR-1:0]  act_q;
  logic [NUM_CTR-1:0]  act_set;
  logic [31:0]         sel_cfg;
  logic [63:0]         sel_snap;
  logic [63:0]         sel_thr;
  logic [31:0]         build;

  logic [CFG_W-1:0]    cfg_a  [NUM_CTR];
  logic [CW-1:0]       cnt_a  [NUM_CTR];
  logic [CW-1:0]       snap_a [NUM_CTR];
  logic [63:0]         thr_a  [NUM_CTR];
  logic [NUM_CTR*CW-1:0] cnt_flat;
  logic [NUM_CTR*64-1:0] thr_flat;

  assign clr_all  = strb.ctl & reg_wdata[CTL_CLR_BIT];
  assign snap_all = strb.ctl & reg_wdata[CTL_SNAP_BIT];
  assign build    = build_word(VERSION, 2'(SIZE_CODE), 8'(NUM_CTR), 8'(NUM_EVT));

  evt_ctr_regs #(.NUM_CTR(NUM_CTR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .idx_wdata (reg_wdata[7:0]),
    .sel_cfg   (sel_cfg),
    .sel_snap  (sel_snap),
    .sel_thr   (sel_thr),
    .en_q      (en_q),
    .act_q     (act_q),
    .build     (build),
    .strb      (strb),
    .idx_q     (idx_q),
    .idx_ok    (idx_ok),
    .rdata     (reg_rdata)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    evt_ctr_unit #(.NUM_EVT(NUM_EVT), .CW(CW), .CFG_W(CFG_W)) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .events   (events),
      .sel      (idx_q == 8'(g)),
      .strb     (strb),
      .wdata    (reg_wdata),
      .clr_all  (clr_all),
      .snap_all (snap_all),
      .cfg_q    (cfg_a[g]),
      .cnt_q    (cnt_a[g]),
      .snap_q   (snap_a[g]),
      .thr_q    (thr_a[g]),
      .match    (match[g])
    );
    assign cnt_flat[g*CW +: CW] = cnt_a[g];
    assign thr_flat[g*64 +: 64] = thr_a[g];
  end

  always_comb begin
    sel_cfg  = '0;
    sel_snap = '0;
    sel_thr  = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (idx_q == 8'(i)) begin
        sel_cfg  = 32'(cfg_a[i]);
        sel_snap = 64'(snap_a[i]);
        sel_thr  = thr_a[i];
      end
    end
  end

  evt_ctr_irq #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .match   (match),
    .en_wr   (strb.en),
    .act_w1c (strb.act),
    .wbits   (reg_wdata[NUM_CTR-1:0]),
    .en_q    (en_q),
    .act_q   (act_q),
    .act_set (act_set),
    .irq     (irq)
  );

endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CW      = 48
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [11:0]           reg_addr,
  input logic [31:0]           reg_wdata,
  input logic                  idx_ok,
  input logic [NUM_CTR-1:0]    en_q,
  input logic [NUM_CTR-1:0]    act_q,
  input logic [NUM_CTR*CW-1:0] cnt_flat,
  input logic [NUM_CTR*64-1:0] thr_flat
);

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTL && reg_wdata[CTL_CLR_BIT]) |=> (cnt_flat == '0)); // R4

  AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EN) |=> (en_q == $past(reg_wdata[NUM_CTR-1:0]))); // R8

  AST_BAD_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !idx_ok && (reg_addr == A_THR_LO || reg_addr == A_THR_HI))
      |=> $stable(thr_flat)); // R10

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q[i]) |-> $past(en_q[i])); // R7

    AST_W1C_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_ACT && reg_wdata[i]) |=> (!act_q[i] && !en_q[i])); // R9
  end

endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .idx_ok    (idx_ok),
  .en_q      (en_q),
  .act_q     (act_q),
  .cnt_flat  (cnt_flat),
  .thr_flat  (thr_flat)
);

// File: tb/test_evt_ctr_bank.sv
`timescale 1ns/1ps
module test_evt_ctr_bank;

  localparam int NUM_CTR   = 4;
  localparam int NUM_EVT   = 8;
  localparam int SIZE_CODE = 1;
  localparam logic [7:0] VERSION = 8'h02;
  localparam int CWB = 32 + 16 * SIZE_CODE;
  localparam logic [31:0] HI_MASK = 32'((64'd1 << (CWB - 32)) - 64'd1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-1:0] events = '0;
  logic               reg_wr = 1'b0;
  logic [11:0]        reg_addr = '0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        reg_rdata;
  logic               irq;

  int checks = 0;
  int failures = 0;
  int exp_cnt [NUM_CTR];
  int cfg_m   [NUM_CTR];

  always #2.5 clk = ~clk;

  evt_ctr_bank #(.NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .SIZE_CODE(SIZE_CODE),
                 .VERSION(VERSION)) i_evt_ctr_bank (
    .clk(clk), .rst_n(rst_n), .events(events), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic bit picks(int cfg, logic [NUM_EVT-1:0] ev);
    if (cfg < 1 || cfg > NUM_EVT) return 1'b0;
    return ev[cfg-1];
  endfunction

  function automatic logic [31:0] exp_build();
    return (32'(NUM_EVT) << 24) | (32'(NUM_CTR) << 16) | (32'd1 << 10)
         | (32'(SIZE_CODE) << 8) | 32'(VERSION);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and build word
    check("R1 irq", 32'(irq), 32'd0);
    rd_chk("R1 build", 12'h25A, exp_build());
    rd_chk("R1 idx", 12'h256, 32'd0);
    rd_chk("R1 en", 12'h25E, 32'd0);
    rd_chk("R1 act", 12'h25F, 32'd0);
    rd_chk("R1 thr", 12'h25C, 32'd0);
    rd_chk("R1 cnt", 12'h250, 32'd0);
    rd_chk("R1 ctl reads zero", 12'h255, 32'd0);
    rd_chk("R1 unmapped", 12'h300, 32'd0);

    // R3 R2 program condition selects through the index
    cfg_m[0] = 1; cfg_m[1] = 3; cfg_m[2] = 0; cfg_m[3] = NUM_EVT + 1;
    for (int i = 0; i < NUM_CTR; i++) begin
      wr(12'h256, 32'(i));
      wr(12'h254, 32'(cfg_m[i]));
      exp_cnt[i] = 0;
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      wr(12'h256, 32'(i));
      rd_chk("R3 cfg readback", 12'h254, 32'(cfg_m[i]));
    end

    // R2 random event stream
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      events = NUM_EVT'($urandom);
      for (int i = 0; i < NUM_CTR; i++)
        if (picks(cfg_m[i], events)) exp_cnt[i]++;
    end
    @(negedge clk);
    events = '0;
    wr(12'h255, 32'h0002_0000);
    for (int i = 0; i < NUM_CTR; i++) begin
      wr(12'h256, 32'(i));
      rd_chk("R2 count low", 12'h250, 32'(exp_cnt[i]));
      rd_chk("R2 count high", 12'h251, 32'd0);
    end

    // R6 count write halves, width masking
    wr(12'h256, 32'd1);
    wr(12'h250, 32'hDEAD_BEEF);
    wr(12'h251, 32'hFFFF_FFFF);
    wr(12'h255, 32'h0002_0000);
    rd_chk("R6 low write", 12'h250, 32'hDEAD_BEEF);
    rd_chk("R6 high masked", 12'h251, HI_MASK);

    // R5 snapshot holds while counting
    @(negedge clk); events = 8'h04;
    repeat (4) @(negedge clk);
    events = '0;
    rd_chk("R5 snapshot held", 12'h250, 32'hDEAD_BEEF);
    wr(12'h255, 32'h0002_0000);
    rd_chk("R5 new snapshot", 12'h250, 32'hDEAD_BEF3);

    // R4 R5 clear and snapshot together: snapshot keeps pre-clear value
    wr(12'h255, 32'h0003_0000);
    rd_chk("R5 pre-clear snapshot", 12'h250, 32'hDEAD_BEF3);
    rd_chk("R5 pre-clear snapshot hi", 12'h251, HI_MASK);
    wr(12'h255, 32'h0002_0000);
    rd_chk("R4 cleared low", 12'h250, 32'd0);
    rd_chk("R4 cleared high", 12'h251, 32'd0);

    // R7 R8 threshold hit with enable: exact cycle
    wr(12'h256, 32'd0);
    wr(12'h250, 32'd0);
    wr(12'h25C, 32'd5);
    wr(12'h25D, 32'd0);
    rd_chk("R3 thr low readback", 12'h25C, 32'd5);
    wr(12'h25E, 32'h1);
    rd_chk("R8 en readback", 12'h25E, 32'h1);
    @(negedge clk); events = 8'h01;
    repeat (5) @(negedge clk);
    check("R7 no irq before match edge", 32'(irq), 32'd0);
    @(negedge clk);
    check("R7 irq on match edge", 32'(irq), 32'd1);
    events = '0;
    rd_chk("R7 pending bit0", 12'h25F, 32'h1);

    // R9 W1C clears pending and enable, re-arm does not re-fire
    wr(12'h25F, 32'h1);
    rd_chk("R9 pending cleared", 12'h25F, 32'h0);
    rd_chk("R9 enable cleared", 12'h25E, 32'h0);
    check("R9 irq low", 32'(irq), 32'd0);
    wr(12'h25E, 32'h1);
    repeat (3) @(negedge clk);
    check("R9 re-arm past threshold", 32'(irq), 32'd0);

    // R7 match without enable
    wr(12'h256, 32'd1);
    wr(12'h250, 32'd0);
    wr(12'h251, 32'd0);
    wr(12'h25C, 32'd2);
    @(negedge clk); events = 8'h04;
    repeat (5) @(negedge clk);
    events = '0;
    rd_chk("R7 no pending without enable", 12'h25F, 32'h0);
    check("R7 no irq without enable", 32'(irq), 32'd0);

    // R8 R9 two pending counters
    wr(12'h256, 32'd2); wr(12'h254, 32'd2); wr(12'h25C, 32'd1);
    wr(12'h256, 32'd3); wr(12'h254, 32'(NUM_EVT)); wr(12'h25C, 32'd1);
    wr(12'h255, 32'h0001_0000);
    wr(12'h25E, 32'hD);
    @(negedge clk); events = 8'h82;
    @(negedge clk); events = '0;
    repeat (2) @(negedge clk);
    rd_chk("R8 two pending", 12'h25F, 32'hC);
    check("R8 irq high", 32'(irq), 32'd1);
    wr(12'h25F, 32'h4);
    rd_chk("R9 one cleared", 12'h25F, 32'h8);
    rd_chk("R9 enable after clear", 12'h25E, 32'h9);
    check("R8 irq from remaining", 32'(irq), 32'd1);
    wr(12'h25F, 32'hFFFF_FFFF);
    rd_chk("R9 all cleared", 12'h25F, 32'h0);
    rd_chk("R9 all enables cleared", 12'h25E, 32'h0);
    check("R9 irq after clear all", 32'(irq), 32'd0);

    // R10 out-of-range index
    wr(12'h256, 32'(NUM_CTR));
    wr(12'h25C, 32'h1234);
    wr(12'h254, 32'd5);
    rd_chk("R10 cfg reads zero", 12'h254, 32'd0);
    rd_chk("R10 thr reads zero", 12'h25C, 32'd0);
    rd_chk("R3 idx readback", 12'h256, 32'(NUM_CTR));
    wr(12'h256, 32'd200);
    wr(12'h250, 32'h55);
    wr(12'h256, 32'd0);
    rd_chk("R10 thr untouched", 12'h25C, 32'd5);
    rd_chk("R10 cfg untouched", 12'h254, 32'd1);

    // R3 64-bit threshold halves
    wr(12'h25D, 32'hA5A5_0001);
    rd_chk("R3 thr high readback", 12'h25D, 32'hA5A5_0001);
    rd_chk("R3 thr low kept", 12'h25C, 32'd5);

    finish_run();
  end

endmodule